// File: doc/BRIEF.md
# Completion Interrupt Source Router

This block takes one completion pulse per DMA channel and turns those pulses into a small group of interrupt lines. Each of three dedicated lines has its own configuration word. That word names one channel and carries an enable bit. When a dedicated line is enabled, a completion on its chosen channel produces a single-cycle pulse on that line.

Every completion that no enabled dedicated line claims goes to a shared line instead. For that shared line the block keeps a sticky flag per channel. Software reads those flags through one word and clears them by writing ones to a second word. The shared line stays high as long as any flag is set.

Software reaches the block through a plain register port: a write strobe, a word address, write data, and read data that is registered. Word 0, 1 and 2 hold the configuration of dedicated lines 1, 2 and 3. Word 4 holds the flags. Word 5 is the clear word.

Top module: `irq_route`

## Requirements
- R1: After a synchronous reset, every interrupt output is 0, all configuration words read 0 (all dedicated mappings disabled), and the flag word reads 0.
- R2: In the configuration word of a dedicated line, bits [4:0] select the channel and bit 5 enables the line. A read returns those six bits with every higher bit 0, and written bits above bit 5 are dropped.
- R3: An enabled dedicated line pulses high for exactly one cycle, on the clock edge that samples a completion of its selected channel. A disabled line, or a line whose selection is not an implemented channel, never pulses.
- R4: Flag bit n (word 4, read-only) becomes set when channel n completes without being claimed by an enabled dedicated line. It stays set until it is cleared, and writes to word 4 are ignored.
- R5: A completion on a channel claimed by an enabled dedicated line leaves that channel's flag unchanged. Selecting a channel with the enable bit at 0 does not claim it.
- R6: Writing to word 5 clears every flag whose bit in the written data is 1. Zero bits have no effect, and word 5 reads as 0.
- R7: If a completion that sets flag n and a clear of flag n arrive in the same cycle, flag n ends set.
- R8: Output line 0 is high exactly while at least one flag is set. It changes on the same edge as the flags.
- R9: The read data shows, one edge later, the addressed word as it was before that edge. Unused addresses (3, 6, 7) read 0.
- R10: Two dedicated lines that are enabled with the same channel both pulse on its completion. A configuration write takes effect for completions from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| done_i | input | NUM_CH | One-cycle completion pulse per channel |
| irq_o | output | NUM_LINES+1 | Bit 0 is the shared level line; bits 1 to 3 are the dedicated pulse lines |

## Verification
The bench goes after four corner cases.

- A completion and a clear aimed at the same flag in one cycle. A design that lets the clear win loses that interrupt.
- A channel selected by a dedicated line whose enable bit is 0. A design that excludes it anyway drops the flag, and one that ignores the enable pulses a disabled line.
- Clear writes containing zero bits, and writes aimed at the read-only flag word. A careless decoder wipes or corrupts flags here.
- Two dedicated lines sharing one channel, and a configuration write that lands in the same cycle as a completion. These expose a priority encoder in place of a parallel match, and a configuration path that uses the new value one cycle early.

Random traffic is checked against a reference model every cycle, and it also catches read data that is off by one cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_CFG_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FLAG     = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CLEAR    = 3'd5;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } route_cfg_t;

  localparam int CFG_W = $bits(route_cfg_t);
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CFG_W-1:0]            wr_data,
  output route_cfg_t [NUM_LINES-1:0]  cfg_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [ADDR_W-1:0] MY_ADDR = ADR_CFG_BASE + ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[g] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)
        cfg_o[g] <= route_cfg_t'(wr_data);
    end
  end
endmodule

// File: rtl/irq_route_match.sv
module irq_route_match
  import irq_route_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 3
) (
  input  route_cfg_t [NUM_LINES-1:0] cfg_i,
  input  logic [NUM_CH-1:0]          done_i,
  output logic [NUM_LINES-1:0]       hit_o,
  output logic [NUM_CH-1:0]          claim_o
);
  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] done_pad;

  always_comb begin
    done_pad = '0;
    done_pad[NUM_CH-1:0] = done_i;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hit
    assign hit_o[g] = cfg_i[g].en & done_pad[cfg_i[g].sel];
  end

  always_comb begin
    claim_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (cfg_i[l].en && cfg_i[l].sel == SEL_W'(c))
          claim_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_route_flags.sv
module irq_route_flags #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_q,
  output logic              any_q
);
  logic [NUM_CH-1:0] flag_n;

  assign flag_n = (flag_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      any_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      any_q  <= |flag_n;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_CH-1:0]    done_i,
  output logic [NUM_LINES:0]   irq_o
);
  route_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]       hit;
  logic [NUM_LINES-1:0]       hit_q;
  logic [NUM_CH-1:0]          claim;
  logic [NUM_CH-1:0]          set_mask;
  logic [NUM_CH-1:0]          clr_mask;
  logic [NUM_CH-1:0]          flag_q;
  logic                       any_q;
  logic [DATA_W-1:0]          rd_mux;
  logic [NUM_LINES-1:0]       cfg_en;

  irq_route_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata[CFG_W-1:0]),
    .cfg_o   (cfg)
  );

  irq_route_match #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_match (
    .cfg_i   (cfg),
    .done_i  (done_i),
    .hit_o   (hit),
    .claim_o (claim)
  );

  assign set_mask = done_i & ~claim;
  assign clr_mask = (reg_wr && reg_addr == ADR_CLEAR) ? reg_wdata[NUM_CH-1:0] : '0;

  irq_route_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .flag_q (flag_q),
    .any_q  (any_q)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_en
    assign cfg_en[g] = cfg[g].en;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADR_FLAG)
      rd_mux[NUM_CH-1:0] = flag_q;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (reg_addr == ADR_CFG_BASE + ADDR_W'(l))
        rd_mux[CFG_W-1:0] = cfg[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= '0;
      reg_rdata <= '0;
    end else begin
      hit_q     <= hit;
      reg_rdata <= rd_mux;
    end
  end

  assign irq_o = {hit_q, any_q};
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NUM_LINES = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic [2:0]           reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [NUM_CH-1:0]    done_i,
  input logic [NUM_LINES:0]   irq_o,
  input logic [NUM_CH-1:0]    flag_q,
  input logic [NUM_CH-1:0]    claim,
  input logic [NUM_LINES-1:0] cfg_en
);
  logic [NUM_CH-1:0] set_c;
  logic [NUM_CH-1:0] clr_c;

  assign set_c = done_i & ~claim;
  assign clr_c = (reg_wr && reg_addr == ADR_CLEAR) ? reg_wdata[NUM_CH-1:0] : '0;

  AST_LEVEL_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] == (|flag_q)); // R8

  AST_CLAIMED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|(done_i & claim & ~flag_q)) |=> ((flag_q & $past(done_i & claim & ~flag_q)) == '0)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (|set_c) |=> ((flag_q & $past(set_c)) == $past(set_c))); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_c & ~set_c)) |=> ((flag_q & $past(clr_c & ~set_c)) == '0)); // R6

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
      !cfg_en[g] |=> !irq_o[g+1]); // R3
  end
endmodule

bind irq_route irq_route_chk #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .done_i    (done_i),
  .irq_o     (irq_o),
  .flag_q    (flag_q),
  .claim     (claim),
  .cfg_en    (cfg_en)
);

// File: tb/tb_irq_route.sv
`timescale 1ns/1ps
module tb_irq_route;
  localparam int NCH = 32;
  localparam int NL  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] done_i = '0;
  logic [NL:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [5:0]  cfg_m [NL];
  logic [31:0] flags_m;

  always #2.5 clk = ~clk;

  irq_route #(.NUM_CH(NCH), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] rd_model(logic [2:0] a);
    if (a < 3) return {26'b0, cfg_m[a]};
    if (a == 3'd4) return flags_m;
    return 32'h0;
  endfunction

  function automatic logic [31:0] claim_model();
    logic [31:0] m = '0;
    for (int l = 0; l < NL; l++)
      if (cfg_m[l][5] && int'(cfg_m[l][4:0]) < NCH) m[cfg_m[l][4:0]] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare at the next falling edge.
  task automatic cyc(logic [31:0] d, bit w, logic [2:0] a, logic [31:0] wd, string tag);
    logic [31:0] exp_rd, clr, nflags;
    logic [NL:0] exp_irq;
    done_i = d; reg_wr = w; reg_addr = a; reg_wdata = wd;
    exp_rd = rd_model(a);
    clr    = (w && a == 3'd5) ? wd : 32'h0;
    nflags = (flags_m & ~clr) | (d & ~claim_model());
    exp_irq[0] = |nflags;
    for (int l = 0; l < NL; l++)
      exp_irq[l+1] = cfg_m[l][5] && d[cfg_m[l][4:0]];
    @(negedge clk);
    check(irq_o == exp_irq, {tag, " irq (R3/R8)"}, 32'(irq_o), 32'(exp_irq));
    check(reg_rdata == exp_rd, {tag, " rdata (R9)"}, reg_rdata, exp_rd);
    flags_m = nflags;
    if (w && a < 3) cfg_m[a] = wd[5:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < NL; l++) cfg_m[l] = '0;
    flags_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(irq_o == '0, "R1 irq after reset", 32'(irq_o), 0);
    check(reg_rdata == '0, "R1 rdata after reset", reg_rdata, 0);
    cyc('0, 0, 3'd0, 0, "R1 cfg0");
    cyc('0, 0, 3'd4, 0, "R1 flags");
    // R2: cfg write keeps six bits
    cyc('0, 1, 3'd0, 32'hABCDEFE7, "R2 write line1 sel7 en");
    cyc('0, 0, 3'd0, 0, "R2 readback");
    check(reg_rdata == 32'h27, "R2 line1 readback", reg_rdata, 32'h27);
    // R3/R5: claimed completion pulses, no flag
    cyc(32'h80, 0, 3'd4, 0, "R3 R5 ch7 claimed");
    cyc('0, 0, 3'd4, 0, "R3 pulse ends, R5 flag clear");
    check(reg_rdata == 0, "R5 ch7 flag stays clear", reg_rdata, 0);
    // R5: disabled mapping does not claim; R10 shared channel
    cyc('0, 1, 3'd1, 32'h09, "R5 line2 sel9 disabled");
    cyc('0, 1, 3'd2, 32'h27, "R10 line3 sel7 en");
    cyc(32'h280, 0, 3'd4, 0, "R10 ch7 both lines, R5 ch9 flags");
    cyc('0, 0, 3'd4, 0, "R4 flag read");
    check(reg_rdata == 32'h200, "R4 ch9 flag", reg_rdata, 32'h200);
    check(irq_o == 4'b0001, "R8 level high only", 32'(irq_o), 1);
    // R4: write to flag word ignored
    cyc('0, 1, 3'd4, 32'hFFFFFFFF, "R4 write ignored");
    // R6: zeros no effect, ones clear, reads 0
    cyc('0, 1, 3'd5, 32'h0, "R6 zero clear");
    cyc('0, 0, 3'd5, 0, "R6 clear word reads 0");
    cyc('0, 1, 3'd5, 32'h200, "R6 clear ch9");
    check(irq_o[0] == 1'b0, "R6 level drops", 32'(irq_o), 0);
    // R7: set beats clear
    cyc(32'h8, 1, 3'd5, 32'h8, "R7 set and clear ch3");
    check(irq_o[0] == 1'b1, "R7 ch3 flag kept", 32'(irq_o), 1);
    // R10: cfg write same cycle as completion uses old cfg
    cyc(32'h10, 1, 3'd0, 32'h24, "R10 write sel4 while ch4 completes");
    cyc(32'h10, 0, 3'd4, 0, "R10 new cfg claims ch4");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d  = $urandom & $urandom & $urandom;
      bit          w  = ($urandom % 4) == 0;
      logic [2:0]  a  = 3'($urandom);
      logic [31:0] wd = $urandom;
      cyc(d, w, a, wd, "random");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule